// File: doc/BRIEF.md
# Dual-Mode Stack Push Sequencer

This block executes the stack-push part of a CPU with an 8-bit data bus and two address modes. It takes an opcode byte stream over a valid/ready handshake and recognises three push instructions: accumulator with flags, index register X, and index register Y. It then writes the pushed bytes to memory one byte per cycle. In the wide mode it uses a 24-bit stack pointer and pushes three bytes. In the narrow mode it uses a 16-bit stack pointer and pushes two bytes. The block owns both stack pointers.

The width of each push is chosen per instruction. A global mode input picks the width, unless a one-byte width prefix comes first: the narrow prefix forces the narrow form and the wide prefix forces the wide form. When an accumulator push takes the wide form, it adds a zero byte above the accumulator. When an index push takes the wide form, it adds the register's upper byte. A byte that cannot follow the prefix seen before it raises a one-cycle illegal pulse. The decoder then returns to idle and nothing is written.

Top module: `stack_push_seq`

## Requirements
- R1: A wide accumulator push writes 00h to wide pointer minus 1, then `reg_a` to minus 2, then `reg_f` to minus 3. After that the wide pointer drops by 3.
- R2: A narrow accumulator push writes `reg_a` to narrow pointer minus 1, then `reg_f` to minus 2. After that the narrow pointer drops by 2. During narrow writes, address bits [23:16] are 00h.
- R3: A wide index push writes register bits [23:16] to wide pointer minus 1, bits [15:8] to minus 2 and bits [7:0] to minus 3. After that the wide pointer drops by 3.
- R4: A narrow index push writes register bits [15:8] to narrow pointer minus 1 and bits [7:0] to minus 2. After that the narrow pointer drops by 2.
- R5: Byte encodings: F5h is the accumulator push. DDh followed by E5h pushes index X. FDh followed by E5h pushes index Y. In idle, any other byte, E5h included, is consumed with no write, no illegal pulse and no pointer change.
- R6: Prefix 52h forces the narrow form and prefix 49h forces the wide form for the next instruction, whatever `mode_long` is. The override applies to that one instruction only.
- R7: The block accepts one opcode byte per cycle. Writes begin in the cycle after the last opcode byte and go out one per cycle at strictly descending addresses. `done` is high only in the final write cycle. Accumulator push totals are 3 cycles narrow, 4 wide, 4 narrow with prefix and 5 wide with prefix. Index push totals are 4, 5, 5 and 6.
- R8: `op_ready` is low in every cycle in which a write is driven, and high again in the cycle after `done`.
- R9: A stack pointer changes only on the clock edge that ends a `done` cycle. The pointer of the other mode does not change.
- R10: Pointer arithmetic is modular: the wide pointer wraps within 24 bits and the narrow pointer within 16 bits.
- R11: A byte that does not complete a valid sequence after a prefix raises `illegal` for exactly the following cycle and causes no write. The decoder returns to idle, and any width override is dropped.
- R12: After reset, `mem_we`, `done` and `illegal` are low, `op_ready` is high, and the pointers hold their reset parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Opcode byte is offered |
| op_byte | input | 8 | Opcode byte |
| op_ready | output | 1 | Block can accept an opcode byte |
| mode_long | input | 1 | Global mode: 1 wide, 0 narrow |
| reg_a | input | 8 | Accumulator value |
| reg_f | input | 8 | Flags value |
| reg_ix | input | ADDR_W | Index register X |
| reg_iy | input | ADDR_W | Index register Y |
| mem_addr | output | ADDR_W | Write address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| done | output | 1 | Final write cycle of a push |
| illegal | output | 1 | One-cycle pulse for a bad byte after a prefix |
| spl | output | ADDR_W | Wide stack pointer |
| sps | output | SHORT_W | Narrow stack pointer |

## Verification
The bench keeps the default widths (24 and 16 bits). It sets the wide pointer's reset value to 000004h and the narrow pointer's to 0003h. With these values, the second push in each mode already crosses address zero, so both modular wraps are reached within a few instructions rather than after millions. The random phase then keeps moving through the top of both address spaces, mixing prefixes, global mode and register contents.

// File: rtl/stkpush_pkg.sv
// Shared opcode constants and state types for the stack push sequencer.
// Assumes byte-wide opcodes; nothing here holds state.
package stkpush_pkg;
    localparam logic [7:0] OPC_PUSH_ACC = 8'hF5;
    localparam logic [7:0] OPC_PUSH_IDX = 8'hE5;
    localparam logic [7:0] PFX_IDX_X    = 8'hDD;
    localparam logic [7:0] PFX_IDX_Y    = 8'hFD;
    localparam logic [7:0] PFX_NARROW   = 8'h52;
    localparam logic [7:0] PFX_WIDE     = 8'h49;

    typedef enum logic [1:0] {DEC_IDLE, DEC_WIDTH, DEC_INDEX} dec_state_t;
    typedef enum logic [1:0] {SRC_ACC, SRC_IX, SRC_IY} push_src_t;
    typedef enum logic [1:0] {OVR_NONE, OVR_NARROW, OVR_WIDE} width_ovr_t;
endpackage

// File: rtl/stkpush_decode.sv
// Opcode decoder. Consumes one byte per accepted handshake, tracks width and
// index prefixes, and emits a one-cycle start with the resolved width and the
// payload. Assumes the writer is idle whenever op_ready is high.
module stkpush_decode
    import stkpush_pkg::*;
#(
    parameter int PAY_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [7:0]       op_byte,
    input  logic             seq_busy,
    input  logic             mode_long,
    input  logic [7:0]       reg_a,
    input  logic [7:0]       reg_f,
    input  logic [PAY_W-1:0] reg_ix,
    input  logic [PAY_W-1:0] reg_iy,
    output logic             op_ready,
    output logic             start,
    output logic             start_long,
    output logic [PAY_W-1:0] start_payload,
    output logic             illegal
);
    dec_state_t state_q, state_d;
    width_ovr_t ovr_q, ovr_d;
    push_src_t  idx_q, idx_d, src;
    logic       illegal_d;
    logic       accept;

    // Handshake: bytes are taken only while no push is being written
    assign op_ready = !seq_busy;
    assign accept   = op_valid && op_ready;

    // Width resolution: a prefix wins over the global mode bit
    assign start_long = (ovr_q == OVR_WIDE)   ? 1'b1 :
                        (ovr_q == OVR_NARROW) ? 1'b0 : mode_long;

    // Next-state decode of the accepted byte
    always_comb begin
        state_d   = state_q;
        ovr_d     = ovr_q;
        idx_d     = idx_q;
        start     = 1'b0;
        illegal_d = 1'b0;
        src       = SRC_ACC;
        if (accept) begin
            case (state_q)
                DEC_IDLE: begin
                    case (op_byte)
                        PFX_NARROW:   begin state_d = DEC_WIDTH; ovr_d = OVR_NARROW; end
                        PFX_WIDE:     begin state_d = DEC_WIDTH; ovr_d = OVR_WIDE;   end
                        PFX_IDX_X:    begin state_d = DEC_INDEX; idx_d = SRC_IX;     end
                        PFX_IDX_Y:    begin state_d = DEC_INDEX; idx_d = SRC_IY;     end
                        OPC_PUSH_ACC: start = 1'b1;
                        default:      ;
                    endcase
                end
                DEC_WIDTH: begin
                    case (op_byte)
                        PFX_IDX_X:    begin state_d = DEC_INDEX; idx_d = SRC_IX; end
                        PFX_IDX_Y:    begin state_d = DEC_INDEX; idx_d = SRC_IY; end
                        OPC_PUSH_ACC: begin start = 1'b1; state_d = DEC_IDLE; ovr_d = OVR_NONE; end
                        default:      begin illegal_d = 1'b1; state_d = DEC_IDLE; ovr_d = OVR_NONE; end
                    endcase
                end
                DEC_INDEX: begin
                    if (op_byte == OPC_PUSH_IDX) begin
                        start = 1'b1;
                        src   = idx_q;
                    end else begin
                        illegal_d = 1'b1;
                    end
                    state_d = DEC_IDLE;
                    ovr_d   = OVR_NONE;
                end
                default: begin
                    state_d = DEC_IDLE;
                    ovr_d   = OVR_NONE;
                end
            endcase
        end
    end

    // Payload select: the accumulator form carries a zero upper byte
    always_comb begin
        start_payload = '0;
        case (src)
            SRC_IX:  start_payload = reg_ix;
            SRC_IY:  start_payload = reg_iy;
            default: start_payload[15:0] = {reg_a, reg_f};
        endcase
    end

    // Decoder state, prefix memory and illegal pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
            ovr_q   <= OVR_NONE;
            idx_q   <= SRC_IX;
            illegal <= 1'b0;
        end else begin
            state_q <= state_d;
            ovr_q   <= ovr_d;
            idx_q   <= idx_d;
            illegal <= illegal_d;
        end
    end
endmodule

// File: rtl/stkpush_writer.sv
// Byte write sequencer. After a start it drives one write per cycle, from the
// pointer minus 1 downward, most significant payload byte first. It flags done
// on the last write. Assumes the pointers stay stable while it is busy.
module stkpush_writer #(
    parameter int ADDR_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_long,
    input  logic [ADDR_W-1:0]  start_payload,
    input  logic [ADDR_W-1:0]  spl,
    input  logic [SHORT_W-1:0] sps,
    output logic               busy,
    output logic               long_q,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               done
);
    localparam int LONG_N  = ADDR_W / 8;
    localparam int SHORT_N = SHORT_W / 8;
    localparam int CNT_W   = $clog2(LONG_N + 1);

    logic [ADDR_W-1:0] payload_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  nbytes;
    logic [CNT_W-1:0]  sel;
    logic [7:0]        pay_bytes [LONG_N];

    // Split the payload into bytes, one lane per generate step
    for (genvar g = 0; g < LONG_N; g++) begin : g_lane
        assign pay_bytes[g] = payload_q[8*g +: 8];
    end

    assign nbytes = long_q ? CNT_W'(LONG_N) : CNT_W'(SHORT_N);
    assign sel    = nbytes - cnt_q;
    assign mem_we = busy;
    assign done   = busy && (cnt_q == nbytes);

    // Address: pointer minus write count, narrow form zero-extended
    always_comb begin
        if (long_q) begin
            mem_addr = spl - ADDR_W'(cnt_q);
        end else begin
            mem_addr = '0;
            mem_addr[SHORT_W-1:0] = sps - SHORT_W'(cnt_q);
        end
    end

    // Data: pick the payload lane that matches this write
    always_comb begin
        mem_wdata = 8'h00;
        for (int i = 0; i < LONG_N; i++) begin
            if (sel == CNT_W'(i)) mem_wdata = pay_bytes[i];
        end
    end

    // Sequencer registers: launch on start, step each cycle, stop on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            long_q    <= 1'b0;
            cnt_q     <= '0;
            payload_q <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            long_q    <= start_long;
            cnt_q     <= CNT_W'(1);
            payload_q <= start_payload;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/stkpush_sp.sv
// One stack pointer register. It steps down by STEP, modulo 2**W, when dec_en
// is high. Assumes the caller raises dec_en only on the final write cycle.
module stkpush_sp #(
    parameter int           W     = 24,
    parameter int           STEP  = 3,
    parameter logic [W-1:0] RESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dec_en,
    output logic [W-1:0] sp
);
    // Pointer register with modular decrement
    always_ff @(posedge clk) begin
        if (!rst_n)      sp <= RESET;
        else if (dec_en) sp <= sp - W'(STEP);
    end
endmodule

// File: rtl/stack_push_seq.sv
// Top of the dual-mode stack push sequencer: decoder, byte writer and the two
// stack pointers. Assumes ADDR_W and SHORT_W are multiples of 8, with
// SHORT_W at least 16 and below ADDR_W.
module stack_push_seq #(
    parameter int                   ADDR_W    = 24,
    parameter int                   SHORT_W   = 16,
    parameter logic [ADDR_W-1:0]    SPL_RESET = '0,
    parameter logic [SHORT_W-1:0]   SPS_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [7:0]         op_byte,
    output logic               op_ready,
    input  logic               mode_long,
    input  logic [7:0]         reg_a,
    input  logic [7:0]         reg_f,
    input  logic [ADDR_W-1:0]  reg_ix,
    input  logic [ADDR_W-1:0]  reg_iy,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               mem_we,
    output logic               done,
    output logic               illegal,
    output logic [ADDR_W-1:0]  spl,
    output logic [SHORT_W-1:0] sps
);
    localparam int LONG_N  = ADDR_W / 8;
    localparam int SHORT_N = SHORT_W / 8;

    logic              seq_busy;
    logic              start;
    logic              start_long;
    logic [ADDR_W-1:0] start_payload;
    logic              wr_long;

    stkpush_decode #(.PAY_W(ADDR_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .seq_busy(seq_busy), .mode_long(mode_long), .reg_a(reg_a), .reg_f(reg_f),
        .reg_ix(reg_ix), .reg_iy(reg_iy), .op_ready(op_ready), .start(start),
        .start_long(start_long), .start_payload(start_payload), .illegal(illegal)
    );

    stkpush_writer #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .start_long(start_long),
        .start_payload(start_payload), .spl(spl), .sps(sps), .busy(seq_busy),
        .long_q(wr_long), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done)
    );

    stkpush_sp #(.W(ADDR_W), .STEP(LONG_N), .RESET(SPL_RESET)) u_spl (
        .clk(clk), .rst_n(rst_n), .dec_en(done && wr_long), .sp(spl)
    );

    stkpush_sp #(.W(SHORT_W), .STEP(SHORT_N), .RESET(SPS_RESET)) u_sps (
        .clk(clk), .rst_n(rst_n), .dec_en(done && !wr_long), .sp(sps)
    );
endmodule

// File: rtl/stkpush_checker.sv
// Protocol checker for stack_push_seq, attached by bind. It observes ports and
// the writer's latched width and drives nothing.
module stkpush_checker #(
    parameter int ADDR_W  = 24,
    parameter int SHORT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_ready,
    input logic               mem_we,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               done,
    input logic               illegal,
    input logic [ADDR_W-1:0]  spl,
    input logic [SHORT_W-1:0] sps,
    input logic               wr_long
);
    // R8: no byte is accepted while a write is on the bus
    a_r8_ready_low_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !op_ready);

    // R7: done only marks a write cycle
    a_r7_done_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_we);

    // R7: a non-final write is followed by a write one address lower
    a_r7_descending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !done) |=> (mem_we &&
            (mem_addr[SHORT_W-1:0] == $past(mem_addr[SHORT_W-1:0]) - SHORT_W'(1))));

    // R9: pointers hold outside a done cycle
    a_r9_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(spl) && $stable(sps)));

    // R9 R10: a wide push moves only the wide pointer, modulo its width
    a_r10_wide_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_long) |=> ((spl == $past(spl) - ADDR_W'(ADDR_W / 8)) && $stable(sps)));

    // R2: narrow writes drive zero above the narrow address
    a_r2_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !wr_long) |-> (mem_addr[ADDR_W-1:SHORT_W] == '0));

    // R11: an illegal pulse never coincides with a write
    a_r11_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_we);

    // R11: the illegal flag is a single-cycle pulse
    a_r11_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);
endmodule

bind stack_push_seq stkpush_checker #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .done(done), .illegal(illegal), .spl(spl), .sps(sps),
    .wr_long(wr_long)
);

// File: tb/sim_stack_push_seq.sv
// Bench for stack_push_seq: directed corner cases followed by seeded random
// pushes, all checked against a bench-side model of the pointers.
module sim_stack_push_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] SPL_INIT = 24'h000004;
    localparam logic [15:0] SPS_INIT = 16'h0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_byte = 8'h00;
    logic        op_ready;
    logic        mode_long = 1'b0;
    logic [7:0]  reg_a = 8'h00, reg_f = 8'h00;
    logic [23:0] reg_ix = '0, reg_iy = '0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, done, illegal;
    logic [23:0] spl;
    logic [15:0] sps;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [23:0] m_spl = SPL_INIT;
    logic [15:0] m_sps = SPS_INIT;

    stack_push_seq #(.ADDR_W(24), .SHORT_W(16), .SPL_RESET(SPL_INIT), .SPS_RESET(SPS_INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .op_ready(op_ready), .mode_long(mode_long), .reg_a(reg_a), .reg_f(reg_f),
        .reg_ix(reg_ix), .reg_iy(reg_iy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .done(done), .illegal(illegal), .spl(spl), .sps(sps)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected total cycles for one push, from the R7 table
    function automatic int exp_cycles(input int src, input int pfx, input bit lng);
        int base = (src == 0) ? 3 : 4;
        return base + (lng ? 1 : 0) + ((pfx != 0) ? 1 : 0);
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        op_valid = 1'b1;
        op_byte  = b;
    endtask

    // src: 0 accumulator, 1 index X, 2 index Y; pfx: 0 none, 1 narrow, 2 wide
    task automatic do_push(input int src, input int pfx);
        bit lng = (pfx == 2) ? 1'b1 : (pfx == 1) ? 1'b0 : mode_long;
        int n = lng ? 3 : 2;
        int t0;
        logic [23:0] pay;
        string req;
        pay = (src == 1) ? reg_ix : (src == 2) ? reg_iy : {8'h00, reg_a, reg_f};
        if (pfx != 0)      req = "R6";
        else if (src == 0) req = lng ? "R1" : "R2";
        else               req = lng ? "R3" : "R4";
        @(negedge clk);
        t0 = cyc + 1;
        op_valid = 1'b0;
        if (pfx == 1) send(8'h52);
        if (pfx == 2) send(8'h49);
        if (pfx != 0 && t0 != cyc) t0 = cyc;
        if (pfx == 0) t0 = cyc + 1;
        if (src == 1) send(8'hDD);
        if (src == 2) send(8'hFD);
        send((src == 0) ? 8'hF5 : 8'hE5);
        if (pfx == 0 && src == 0) t0 = cyc;
        if (pfx == 0 && src != 0) t0 = cyc - 1;
        for (int k = 1; k <= n; k++) begin
            logic [23:0] ea;
            logic [7:0]  ed;
            @(negedge clk);
            op_valid = 1'b0;
            ea = lng ? (m_spl - 24'(k)) : {8'h00, 16'(m_sps - 16'(k))};
            ed = pay[8*(n-k) +: 8];
            check(mem_we === 1'b1, "R7", "write strobe", 32'(mem_we), 1);
            check(mem_addr === ea, (k == n && lng && m_spl < 3) ? "R10" : req, "address", 32'(mem_addr), 32'(ea));
            check(mem_wdata === ed, req, "data", 32'(mem_wdata), 32'(ed));
            check(done === (k == n), "R7", "done", 32'(done), 32'(k == n));
            check(op_ready === 1'b0, "R8", "ready during write", 32'(op_ready), 0);
            if (k == n) check(cyc - t0 + 1 == exp_cycles(src, pfx, lng), "R7", "total cycles",
                              32'(cyc - t0 + 1), 32'(exp_cycles(src, pfx, lng)));
            if (k < n) check(spl === m_spl && sps === m_sps, "R9", "pointer early change",
                             32'(spl), 32'(m_spl));
        end
        if (lng) m_spl = m_spl - 24'd3;
        else     m_sps = m_sps - 16'd2;
        @(negedge clk);
        check(mem_we === 1'b0, "R7", "no extra write", 32'(mem_we), 0);
        check(op_ready === 1'b1, "R8", "ready after done", 32'(op_ready), 1);
        check(spl === m_spl, "R9", "wide pointer", 32'(spl), 32'(m_spl));
        check(sps === m_sps, "R9", "narrow pointer", 32'(sps), 32'(m_sps));
    endtask

    // A bad second byte after a prefix
    task automatic do_illegal(input logic [7:0] p, input logic [7:0] b);
        send(p);
        send(b);
        @(negedge clk);
        op_valid = 1'b0;
        check(illegal === 1'b1, "R11", "illegal pulse", 32'(illegal), 1);
        check(mem_we === 1'b0, "R11", "no write on illegal", 32'(mem_we), 0);
        @(negedge clk);
        check(illegal === 1'b0, "R11", "pulse one cycle", 32'(illegal), 0);
        check(mem_we === 1'b0 && spl === m_spl && sps === m_sps, "R11", "state untouched",
              32'(spl), 32'(m_spl));
    endtask

    // A byte that idle ignores
    task automatic do_ignored(input logic [7:0] b);
        send(b);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            check(mem_we === 1'b0 && illegal === 1'b0, "R5", "ignored byte acts", 32'(mem_we), 0);
            check(op_ready === 1'b1 && spl === m_spl && sps === m_sps, "R5", "ignored byte state",
                  32'(sps), 32'(m_sps));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL R7 watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_we === 1'b0 && done === 1'b0 && illegal === 1'b0, "R12", "reset outputs", 32'(mem_we), 0);
        check(op_ready === 1'b1, "R12", "reset ready", 32'(op_ready), 1);
        check(spl === SPL_INIT && sps === SPS_INIT, "R12", "reset pointers", 32'(spl), 32'(SPL_INIT));

        // Directed: wide pushes, the second one wraps the wide pointer
        mode_long = 1'b1; reg_a = 8'hA5; reg_f = 8'h3C; reg_ix = 24'h123456; reg_iy = 24'h89ABCD;
        do_push(0, 0);
        do_push(1, 0);
        check(spl === 24'hFFFFFE, "R10", "wide wrap", 32'(spl), 32'hFFFFFE);
        // Narrow pushes, the second one wraps the narrow pointer
        mode_long = 1'b0;
        do_push(0, 0);
        do_push(2, 0);
        check(sps === 16'hFFFF, "R10", "narrow wrap", 32'(sps), 32'hFFFF);
        // Overrides against the global mode
        do_push(0, 2);
        do_push(1, 2);
        mode_long = 1'b1;
        do_push(2, 1);
        do_push(0, 1);
        // Ignored bytes and illegal sequences; the override must be dropped
        do_ignored(8'h00);
        do_ignored(8'hE5);
        do_illegal(8'hDD, 8'hF5);
        do_illegal(8'h52, 8'h49);
        do_illegal(8'hFD, 8'h00);
        do_push(0, 0);
        mode_long = 1'b0;
        do_illegal(8'h49, 8'hE5);
        do_push(1, 0);

        // Random phase
        for (int it = 0; it < 60; it++) begin
            mode_long = 1'($urandom_range(0, 1));
            reg_a  = 8'($urandom);
            reg_f  = 8'($urandom);
            reg_ix = 24'($urandom);
            reg_iy = 24'($urandom);
            do_push(int'($urandom_range(0, 2)), int'($urandom_range(0, 2)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule